// File: doc/BRIEF.md
# Write-Once Watchdog Timer

This block is a watchdog timer whose configuration can be set exactly once after reset. An 8-bit mode register picks the counting source and one of eight power-of-two overflow periods. The source is a slow internal oscillator tick, a system clock tick, or nothing (the watchdog is halted). Each source has its own range of exponents. Software must keep the timer from expiring by writing a key byte to a separate service register. Any other byte written there is treated as a fault and raises a reset request at once.

The two counting sources reach the block as single-cycle enable pulses on the block clock. A strap input can lock the timer onto the slow oscillator. While the strap is high, neither the system-clock setting nor the halted setting can take effect. A second write to the mode register is refused and sets a sticky flag that software can read back. The only output to the rest of the chip is a one-cycle reset request. A parameter shifts every period down by a fixed number of octaves, so short test runs can reach every setting.

Top module: `once_wdt`

## Requirements
- R1: After reset the mode register (address 0) reads 0x67, the status register (address 2) reads 0x00 and `rst_req` is low. With this value, code 111 on the slow source is in effect: the first request follows 2^(SLOW_EXP0+7-SCALE_DOWN) slow ticks.
- R2: Bits 7..5 of the mode register always read 011, whatever value was written to them.
- R3: The first write to the mode register after reset stores bits 4..0. Every later write leaves the register unchanged.
- R4: Status bit 0 is a sticky fault flag. The first mode write leaves it at 0. Any later mode write sets it to 1, and only reset clears it. Status bits 7..1 read 0.
- R5: Mode bits 4..3 select the source: 0x selects the slow tick, 10 selects the system tick and 11 halts the timer. The counter advances only on enable pulses of the selected source.
- R6: On the slow source, mode bits 2..0 = k give a period of 2^(SLOW_EXP0+k-SCALE_DOWN) ticks. `rst_req` is high in the cycle after the clock edge that samples the last tick, and counting then restarts from zero.
- R7: On the system source, mode bits 2..0 = k give a period of 2^(SYS_EXP0+k-SCALE_DOWN) ticks, with the same request timing and restart as R6.
- R8: With the timer halted, no tick on either input ever raises `rst_req`.
- R9: While `strap_slow_on` is high, the slow source is always used. A mode write taken while the strap is high stores bit 4 as 0.
- R10: Writing 0xAC to the service register (address 1) clears the counter. A tick in the same cycle is discarded, so a full period starts after the write.
- R11: Writing any value other than 0xAC to the service register raises `rst_req` in the next cycle and clears the counter.
- R12: `rst_req` from an overflow lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| strap_slow_on | input | 1 | Locks the timer onto the slow source |
| slow_tick | input | 1 | One-cycle enable from the slow internal oscillator |
| sys_tick | input | 1 | One-cycle enable from the system clock divider |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 mode, 1 service, 2 status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The bench walks all eight codes on both sources. Each run expects two requests exactly one period apart, which exposes an off-by-one in the terminal count, a wrong exponent base, or a counter that fails to restart. It drives only the unselected tick and confirms silence, which catches a swapped source decode. It sends second and third mode writes and then reads the mode and status registers, which catches a lock that only blocks some fields or a fault flag that is not sticky. It writes the service key in the same cycle as a tick and expects the overflow a full period later, which catches a design that lets the tick win. It also writes a system-source mode with the strap high and reads back bit 4 as 0.

// File: rtl/once_wdt_pkg.sv
package once_wdt_pkg;
  typedef enum logic [1:0] {
    SRC_SLOW = 2'd0,
    SRC_SYS  = 2'd1,
    SRC_OFF  = 2'd2
  } src_e;

  localparam logic [1:0] A_MODE = 2'd0;
  localparam logic [1:0] A_KICK = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;

  localparam logic [7:0] KICK_KEY = 8'hAC;
  localparam logic [7:0] MODE_RST = 8'h67;
  localparam logic [2:0] MODE_TOP = 3'b011;
endpackage

// File: rtl/once_wdt_rst_sync.sv
module once_wdt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sh_q <= '0;
        else         sh_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sh_q <= '0;
        else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/once_wdt_mode.sv
module once_wdt_mode
  import once_wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_mode,
  input  logic [7:0] wdata,
  input  logic       strap,
  output logic [7:0] mode_o,
  output logic       locked_o,
  output logic       illegal_o
);
  logic [4:0] fld_q, fld_d;
  logic       lock_q, lock_d;
  logic       ill_q, ill_d;

  always_comb begin
    fld_d  = fld_q;
    lock_d = lock_q;
    ill_d  = ill_q;
    if (wr_mode) begin
      if (!lock_q) begin
        fld_d  = {wdata[4] & ~strap, wdata[3:0]};
        lock_d = 1'b1;
      end else begin
        ill_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fld_q  <= MODE_RST[4:0];
      lock_q <= 1'b0;
      ill_q  <= 1'b0;
    end else begin
      fld_q  <= fld_d;
      lock_q <= lock_d;
      ill_q  <= ill_d;
    end
  end

  assign mode_o    = {MODE_TOP, fld_q};
  assign locked_o  = lock_q;
  assign illegal_o = ill_q;
endmodule

// File: rtl/once_wdt_count.sv
module once_wdt_count #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             clear,
  input  logic             bad_kick,
  input  logic [CNT_W-1:0] last_i,
  output logic             req_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             req_q, req_d;
  logic             ovf;

  always_comb begin
    ovf   = adv && !clear && !bad_kick && (cnt_q >= last_i);
    cnt_d = cnt_q;
    if (clear || bad_kick) cnt_d = '0;
    else if (ovf)          cnt_d = '0;
    else if (adv)          cnt_d = cnt_q + 1'b1;
    req_d = ovf || bad_kick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      req_q <= req_d;
    end
  end

  assign req_o = req_q;
endmodule

// File: rtl/once_wdt.sv
module once_wdt
  import once_wdt_pkg::*;
#(
  parameter int SLOW_EXP0   = 11,
  parameter int SYS_EXP0    = 13,
  parameter int SCALE_DOWN  = 0,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strap_slow_on,
  input  logic       slow_tick,
  input  logic       sys_tick,
  input  logic       bus_wr,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       rst_req
);
  localparam int MAX_EXP = SYS_EXP0 + 7 - SCALE_DOWN;
  localparam int CNT_W   = MAX_EXP;

  logic             srst_n;
  logic [7:0]       mode_byte;
  logic             mode_locked;
  logic             illegal;
  logic             wr_mode, wr_kick, kick_ok, kick_bad;
  src_e             src_sel;
  logic             adv;
  int               sel_exp;
  logic [CNT_W-1:0] last_val;

  once_wdt_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  assign wr_mode  = bus_wr && (bus_addr == A_MODE);
  assign wr_kick  = bus_wr && (bus_addr == A_KICK);
  assign kick_ok  = wr_kick && (bus_wdata == KICK_KEY);
  assign kick_bad = wr_kick && (bus_wdata != KICK_KEY);

  once_wdt_mode u_mode (
    .clk(clk), .rst_n(srst_n), .wr_mode(wr_mode), .wdata(bus_wdata),
    .strap(strap_slow_on), .mode_o(mode_byte), .locked_o(mode_locked),
    .illegal_o(illegal)
  );

  always_comb begin
    if (strap_slow_on) begin
      src_sel = SRC_SLOW;
    end else begin
      case (mode_byte[4:3])
        2'b10:   src_sel = SRC_SYS;
        2'b11:   src_sel = SRC_OFF;
        default: src_sel = SRC_SLOW;
      endcase
    end
  end

  always_comb begin
    if (src_sel == SRC_SYS) sel_exp = SYS_EXP0 + int'(mode_byte[2:0]) - SCALE_DOWN;
    else                    sel_exp = SLOW_EXP0 + int'(mode_byte[2:0]) - SCALE_DOWN;
    last_val = {CNT_W{1'b1}} >> (MAX_EXP - sel_exp);
    adv = ((src_sel == SRC_SLOW) && slow_tick) ||
          ((src_sel == SRC_SYS) && sys_tick);
  end

  once_wdt_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(srst_n), .adv(adv), .clear(kick_ok),
    .bad_kick(kick_bad), .last_i(last_val), .req_o(rst_req)
  );

  always_comb begin
    case (bus_addr)
      A_MODE:  bus_rdata = mode_byte;
      A_STAT:  bus_rdata = {7'b0, illegal};
      default: bus_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/once_wdt_checker.sv
module once_wdt_checker
  import once_wdt_pkg::*;
(
  input logic       clk,
  input logic       srst_n,
  input logic       strap_slow_on,
  input logic       bus_wr,
  input logic [1:0] bus_addr,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic [7:0] mode_byte,
  input logic       mode_locked,
  input logic       illegal,
  input src_e       src_sel,
  input logic       rst_req
);
  assert_top_bits_R2: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_addr == A_MODE) |-> (bus_rdata[7:5] == 3'b011));

  assert_locked_R3: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_wr && bus_addr == A_MODE && mode_locked) |=> ($stable(mode_byte) && illegal));

  assert_sticky_R4: assert property (@(posedge clk) disable iff (!srst_n)
    illegal |=> illegal);

  assert_strap_src_R9: assert property (@(posedge clk) disable iff (!srst_n)
    strap_slow_on |-> (src_sel == SRC_SLOW));

  assert_strap_store_R9: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_wr && bus_addr == A_MODE && !mode_locked && strap_slow_on) |=> !mode_byte[4]);

  assert_kick_quiet_R10: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_wr && bus_addr == A_KICK && bus_wdata == KICK_KEY) |=> !rst_req);

  assert_bad_kick_R11: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_wr && bus_addr == A_KICK && bus_wdata != KICK_KEY) |=> rst_req);

  assert_pulse_R12: assert property (@(posedge clk) disable iff (!srst_n)
    (rst_req && !(bus_wr && bus_addr == A_KICK && bus_wdata != KICK_KEY)) |=> !rst_req);
endmodule

bind once_wdt once_wdt_checker u_chk (
  .clk(clk), .srst_n(srst_n), .strap_slow_on(strap_slow_on), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .mode_byte(mode_byte), .mode_locked(mode_locked), .illegal(illegal),
  .src_sel(src_sel), .rst_req(rst_req)
);

// File: tb/sim_once_wdt.sv
`timescale 1ns/1ps
module sim_once_wdt;
  localparam logic [1:0] AM = 2'd0, AK = 2'd1, AS = 2'd2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap = 1'b0, slow = 1'b0, sys = 1'b0;
  logic bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic rst_req;

  int cyc = 0;
  int n_cmp = 0, n_bad = 0, pulses = 0;
  bit done = 1'b0;

  typedef struct { int when; string tag; } ev_t;
  ev_t exp_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  once_wdt #(.SCALE_DOWN(9)) u0 (
    .clk(clk), .rst_n(rst_n), .strap_slow_on(strap), .slow_tick(slow),
    .sys_tick(sys), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_req(rst_req)
  );

  // monitor: pops expected request events and compares the cycle
  always @(negedge clk) begin
    if (rst_req) begin
      pulses = pulses + 1;
      n_cmp = n_cmp + 1;
      if (exp_q.size() == 0) begin
        n_bad = n_bad + 1;
        $display("FAIL unexpected rst_req (R8/R12) actual=cycle %0d expected=none", cyc);
      end else begin
        ev_t e;
        e = exp_q.pop_front();
        if (e.when != cyc) begin
          n_bad = n_bad + 1;
          $display("FAIL %s rst_req actual=cycle %0d expected=cycle %0d", e.tag, cyc, e.when);
        end
      end
    end
  end

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    end
  endtask

  task automatic chk(string tag, int act, int expv);
    n_cmp++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic push(int when, string tag);
    ev_t e;
    e.when = when;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic drain(string tag);
    repeat (3) @(negedge clk);
    while (exp_q.size() != 0) begin
      ev_t e;
      e = exp_q.pop_front();
      n_cmp++;
      n_bad++;
      $display("FAIL %s missing rst_req actual=none expected=cycle %0d (%s)", tag, e.when, e.tag);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bus_wr = 1'b0; slow = 1'b0; sys = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, logic [7:0] expv, string tag);
    bus_addr = a;
    #1;
    chk(tag, int'(bus_rdata), int'(expv));
    @(negedge clk);
  endtask

  task automatic run_period(logic [7:0] m, bit use_sys, int n, string tag);
    int c;
    do_reset();
    wr(AM, m);
    rd(AM, m, {tag, " mode readback (R3)"});
    if (use_sys) sys = 1'b1; else slow = 1'b1;
    c = cyc;
    push(c + n, tag);
    push(c + 2 * n, {tag, " restart"});
    repeat (2 * n) @(negedge clk);
    slow = 1'b0; sys = 1'b0;
    drain(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    int c, p0;
    @(negedge clk);
    // R1 reset state and default period (slow, code 7 -> 2^(11+7-9))
    do_reset();
    rd(AM, 8'h67, "R1 mode after reset");
    rd(AS, 8'h00, "R1 status after reset");
    chk("R1 rst_req after reset", int'(rst_req), 0);
    slow = 1'b1; c = cyc;
    push(c + 512, "R1 default period");
    repeat (512) @(negedge clk);
    slow = 1'b0;
    drain("R1");

    // R2/R3/R4 write-once and sticky fault
    do_reset();
    wr(AM, 8'h00);
    rd(AM, 8'h60, "R2 top bits forced");
    rd(AS, 8'h00, "R4 first write no fault");
    wr(AM, 8'h9F);
    rd(AM, 8'h60, "R3 second write ignored");
    rd(AS, 8'h01, "R4 fault set");
    wr(AM, 8'h7B);
    rd(AM, 8'h60, "R3 third write ignored");
    rd(AS, 8'h01, "R4 fault sticky");
    do_reset();
    wr(AM, 8'hFF);
    rd(AM, 8'h7F, "R2 write 0xFF reads 0x7F");

    // R6 slow sweep, R7 system sweep
    for (int k = 0; k < 8; k++)
      run_period(8'h60 | 8'(k), 1'b0, 1 << (2 + k), $sformatf("R6 slow code %0d", k));
    for (int k = 0; k < 8; k++)
      run_period(8'h70 | 8'(k), 1'b1, 1 << (4 + k), $sformatf("R7 sys code %0d", k));

    // R5 only the selected source counts
    do_reset();
    wr(AM, 8'h60);
    sys = 1'b1; p0 = pulses;
    repeat (200) @(negedge clk);
    sys = 1'b0;
    chk("R5 slow mode ignores sys_tick", pulses - p0, 0);
    do_reset();
    wr(AM, 8'h70);
    slow = 1'b1; p0 = pulses;
    repeat (200) @(negedge clk);
    slow = 1'b0;
    chk("R5 sys mode ignores slow_tick", pulses - p0, 0);

    // R8 halted
    do_reset();
    wr(AM, 8'h78);
    slow = 1'b1; sys = 1'b1; p0 = pulses;
    repeat (3000) @(negedge clk);
    slow = 1'b0; sys = 1'b0;
    chk("R8 halted no request", pulses - p0, 0);

    // R9 strap forces slow source
    strap = 1'b1;
    do_reset();
    wr(AM, 8'h70);
    rd(AM, 8'h60, "R9 bit4 stored as 0");
    sys = 1'b1; p0 = pulses;
    repeat (100) @(negedge clk);
    sys = 1'b0;
    chk("R9 sys_tick ignored under strap", pulses - p0, 0);
    slow = 1'b1; c = cyc;
    push(c + 4, "R9 slow period under strap");
    repeat (4) @(negedge clk);
    slow = 1'b0;
    drain("R9");
    strap = 1'b0;

    // R10 key clears counter, tick in same cycle discarded
    do_reset();
    wr(AM, 8'h60);
    slow = 1'b1; c = cyc;
    repeat (3) @(negedge clk);
    push(c + 8, "R10 period restarts after key");
    wr(AK, 8'hAC);
    repeat (4) @(negedge clk);
    slow = 1'b0;
    drain("R10");

    // R11/R12 wrong key gives one-cycle request
    do_reset();
    p0 = pulses; c = cyc;
    push(c + 1, "R11 wrong key request");
    wr(AK, 8'h55);
    drain("R11");
    chk("R12 single pulse on wrong key", pulses - p0, 1);

    summary();
    $finish;
  end
endmodule